// File: doc/BRIEF.md
# Serial Register Write Port

This block is a write-only slave for a three-wire serial link made of an active-low select, a bit clock and a data input. A host microcontroller uses it to load a bank of eight-bit configuration registers. The link may run with no fixed relation to the system clock. All three wires pass through two-flop synchronizers, and the bit-clock rising edge is found inside the system clock domain.

Each frame starts when the select line goes low. The frame begins with a header byte: a seven-bit device address followed by a direction bit. Only the exact device address, with the direction bit set for a write, is accepted. Any other header makes the block ignore the rest of the frame. A pointer byte follows the header. It selects the target register and holds a flag that chooses between two modes:
- the pointer stays fixed for each data byte that follows, or
- the pointer steps forward by one after each data byte is written.

The register contents are always available as one flat output vector.

Top module: `spi_reg_slave`

## Requirements
- R1: While `rst` is high, and after it is released, every register in `regs_flat` reads zero. Register i occupies bits [8i+7:8i].
- R2: Bits are shifted most-significant first on bit-clock rising edges. A header byte of 0x20 (device address 0010000 in bits 7:1, write flag 0 in bit 0) is followed by a pointer byte. The data byte after the pointer byte is written into the register that the pointer selects.
- R3: A frame whose header bits 7:1 differ from 0010000 writes no register.
- R4: A frame whose header bit 0 is 1 (a read request) writes no register.
- R5: When pointer bit 7 is 0, every data byte in the frame is written to the same register, so the last byte written remains.
- R6: When pointer bit 7 is 1, the pointer advances by one after each data byte. It wraps from register 15 to register 0.
- R7: A rising select line ends the frame and discards a partly shifted byte. Bytes that completed earlier in the frame stay written.
- R8: Only pointer bits 3:0 select the register. Bits 6:4 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Frame select, active low, asynchronous |
| spi_sck | input | 1 | Serial bit clock, asynchronous |
| spi_mosi | input | 1 | Serial data input, asynchronous |
| regs_flat | output | REG_COUNT*8 | All register contents, register 0 in the low byte |

## Verification
Two situations are the hardest to reach from the ports. The first is a select rise that lands in the middle of a byte, after good bytes have already been written in the same frame. The stimulus reaches it by sending a complete write and then only five bits of a second byte before raising the select line. The second is the pointer wrapping from the last register to the first. A pointer byte of 0x8E followed by three data bytes drives the pointer through register 15 and on to register 0. After each frame the bench compares the whole flat output against a model array that it updates only from the requirements.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

    localparam int BYTE_W = 8;
    localparam logic [6:0] DEV_ADDR = 7'b0010000;
    localparam int INCR_BIT = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PTR,
        ST_DATA,
        ST_SKIP
    } frame_state_e;

    typedef struct packed {
        logic               en;
        logic [3:0]         idx;
        logic [BYTE_W-1:0]  data;
    } wr_req_t;

    function automatic logic header_ok(input logic [BYTE_W-1:0] b);
        return (b[7:1] == DEV_ADDR) && !b[0];
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign d_out = stg[STAGES-1];
endmodule

// File: rtl/spi_frame_parser.sv
module spi_frame_parser
    import spi_regs_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n_s,
    input  logic             sck_s,
    input  logic             mosi_s,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [BYTE_W-1:0] wr_data
);
    frame_state_e      state;
    logic [2:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [IDX_W-1:0]  ptr;
    logic              incr;
    logic              sck_d;
    logic              sck_rise;
    logic [BYTE_W-1:0] next_byte;
    logic              byte_done;

    assign sck_rise  = sck_s && !sck_d;
    assign next_byte = {shreg[BYTE_W-2:0], mosi_s};
    assign byte_done = sck_rise && (bit_cnt == 3'd7);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            ptr     <= '0;
            incr    <= 1'b0;
            sck_d   <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            sck_d <= sck_s;
            wr_en <= 1'b0;
            if (cs_n_s) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
            end else if (state == ST_IDLE) begin
                state   <= ST_HDR;
                bit_cnt <= '0;
            end else if (sck_rise) begin
                shreg   <= next_byte;
                bit_cnt <= bit_cnt + 3'd1;
                if (byte_done) begin
                    unique case (state)
                        ST_HDR:  state <= header_ok(next_byte) ? ST_PTR : ST_SKIP;
                        ST_PTR: begin
                            ptr   <= next_byte[IDX_W-1:0];
                            incr  <= next_byte[INCR_BIT];
                            state <= ST_DATA;
                        end
                        ST_DATA: begin
                            wr_en   <= 1'b1;
                            wr_idx  <= ptr;
                            wr_data <= next_byte;
                            if (incr) ptr <= ptr + 1'b1;
                        end
                        default: state <= state;
                    endcase
                end
            end
        end
    end

    // R5 / R6: pointer after a write either holds or sits one above the written index
    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (ptr == (incr ? wr_idx + 1'b1 : wr_idx)));

    // R7: a write only follows a cycle with select low
    assert_write_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !$past(cs_n_s));

    // R3 / R4: a rejected frame never produces a write
    assert_skip_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |=> !wr_en);

    // R2: writes only come out of the data phase
    assert_write_from_data_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($past(state) == ST_DATA));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_regs_pkg::*;
#(
    parameter int REG_COUNT = 16,
    localparam int IDX_W = $clog2(REG_COUNT)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  wr_req_t                     req,
    output logic [REG_COUNT*BYTE_W-1:0] flat
);
    logic [BYTE_W-1:0] regs_arr [REG_COUNT];

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) regs_arr[i] <= '0;
            else if (req.en && (req.idx[IDX_W-1:0] == i[IDX_W-1:0])) regs_arr[i] <= req.data;
        end
        assign flat[i*BYTE_W +: BYTE_W] = regs_arr[i];
    end

    // R2: a write request lands in the addressed register one cycle later
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        req.en |=> (regs_arr[$past(req.idx[IDX_W-1:0])] == $past(req.data)));

    // R1: register 0 reads zero in the cycle after reset
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;
    always_ff @(posedge clk) begin
        if (rst_q && !rst) assert_reset_zero_R1: assert (regs_arr[0] == '0);
    end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_regs_pkg::*;
#(
    parameter int REG_COUNT = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        spi_cs_n,
    input  logic                        spi_sck,
    input  logic                        spi_mosi,
    output logic [REG_COUNT*BYTE_W-1:0] regs_flat
);
    localparam int IDX_W = $clog2(REG_COUNT);

    logic [2:0] raw_bus;
    logic [2:0] sync_bus;
    wr_req_t    req;
    logic [IDX_W-1:0] wr_idx;

    assign raw_bus = {spi_cs_n, spi_sck, spi_mosi};

    spi_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (raw_bus),
        .d_out (sync_bus)
    );

    spi_frame_parser #(.IDX_W(IDX_W)) u_parser (
        .clk     (clk),
        .rst     (rst),
        .cs_n_s  (sync_bus[2]),
        .sck_s   (sync_bus[1]),
        .mosi_s  (sync_bus[0]),
        .wr_en   (req.en),
        .wr_idx  (wr_idx),
        .wr_data (req.data)
    );

    assign req.idx = 4'(wr_idx);

    spi_reg_bank #(.REG_COUNT(REG_COUNT)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .flat (regs_flat)
    );
endmodule

// File: tb/spi_reg_slave_test.sv
module spi_reg_slave_test;
    localparam int N = 16;
    localparam int HALF = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic [N*8-1:0] regs_flat;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] model [N];

    always #2.5 clk = ~clk;

    spi_reg_slave #(.REG_COUNT(N)) uut (
        .clk       (clk),
        .rst       (rst),
        .spi_cs_n  (cs_n),
        .spi_sck   (sck),
        .spi_mosi  (mosi),
        .regs_flat (regs_flat)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        logic [N*8-1:0] exp;
        for (int i = 0; i < N; i++) exp[i*8 +: 8] = model[i];
        checks++;
        if (regs_flat !== exp) begin
            failures++;
            $display("FAIL %s regs actual=%h expected=%h", req, regs_flat, exp);
        end
    endtask

    task automatic check_reg(input string req, input int idx, input logic [7:0] val);
        checks++;
        if (regs_flat[idx*8 +: 8] !== val) begin
            failures++;
            $display("FAIL %s reg%0d actual=%h expected=%h", req, idx, regs_flat[idx*8 +: 8], val);
        end
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        wait_clk(HALF * 2);
    endtask

    task automatic cs_end();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(HALF * 3);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = b[i];
            wait_clk(HALF);
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_clk(4);
        rst = 1'b0;
        for (int i = 0; i < N; i++) model[i] = 8'h00;
        wait_clk(2);
    endtask

    task automatic t_reset();
        check_all("R1");
    endtask

    task automatic t_single_write();
        cs_begin(); send_byte(8'h20); send_byte(8'h03); send_byte(8'hA5); cs_end();
        model[3] = 8'hA5;
        check_reg("R2", 3, 8'hA5);
        check_all("R2");
    endtask

    task automatic t_bad_address();
        cs_begin(); send_byte(8'h22); send_byte(8'h04); send_byte(8'hFF); cs_end();
        check_reg("R3", 4, 8'h00);
        check_all("R3");
    endtask

    task automatic t_read_request();
        cs_begin(); send_byte(8'h21); send_byte(8'h03); send_byte(8'h5C); cs_end();
        check_reg("R4", 3, 8'hA5);
        check_all("R4");
    endtask

    task automatic t_fixed_pointer();
        cs_begin(); send_byte(8'h20); send_byte(8'h07);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); cs_end();
        model[7] = 8'h33;
        check_reg("R5", 7, 8'h33);
        check_reg("R5", 8, 8'h00);
        check_all("R5");
    endtask

    task automatic t_auto_increment();
        cs_begin(); send_byte(8'h20); send_byte(8'h8E);
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); cs_end();
        model[14] = 8'h01; model[15] = 8'h02; model[0] = 8'h03;
        check_reg("R6", 15, 8'h02);
        check_reg("R6", 0, 8'h03);
        check_all("R6");
    endtask

    task automatic t_partial_byte();
        cs_begin(); send_byte(8'h20); send_byte(8'h09); send_byte(8'h5A);
        send_bits(8'hFF, 5); cs_end();
        model[9] = 8'h5A;
        check_reg("R7", 9, 8'h5A);
        cs_begin(); send_byte(8'h20); send_bits(8'h0A, 6); cs_end();
        check_all("R7");
    endtask

    task automatic t_upper_ptr_bits();
        cs_begin(); send_byte(8'h20); send_byte(8'h75); send_byte(8'hC3); cs_end();
        model[5] = 8'hC3;
        check_reg("R8", 5, 8'hC3);
        check_all("R8");
    endtask

    task automatic t_reset_again();
        do_reset();
        check_all("R1");
    endtask

    initial begin
        wait_clk(3);
        do_reset();
        t_reset();
        t_single_write();
        t_bad_address();
        t_read_request();
        t_fixed_pointer();
        t_auto_increment();
        t_partial_byte();
        t_upper_ptr_bits();
        t_reset_again();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired before all scenarios completed");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule